// File: doc/BRIEF.md
# Register-Mapped Synchronous Serial Master

This block is a serial peripheral interface master with a register interface. Software configures the frame length, the clock polarity and phase, and a two-stage bit-rate divider. It then writes words to a data address. Those words enter an eight-entry transmit queue. The shift engine pulls them out one at a time and sends each one most significant bit first on `mosi`. It holds `frame_n` low for the whole frame and samples `miso` (or its own `mosi`, when loopback is selected) into an eight-entry receive queue.

Reading the data address returns the oldest received word, right-justified, and removes it from the queue. A status address reports the queue and activity conditions. An interrupt address reports three sources, each gated by its own enable bit: the receive queue reaching its watermark, the transmit queue falling to its watermark, and a sticky overrun flag. The `irq` output is the OR of the three.

Routing the frame enable to individual devices is left to logic outside the block.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, every control register reads 0, status reads 0x03, `irq` is 0, `frame_n` is 1 and `sclk` is 0.
- R2: The register addresses are fixed. Control A is at 0x00 and stores all 16 bits. Control B is at 0x04 and stores bits [6:0]. The prescale register is at 0x10, and its bit 0 always reads 0. Data is at 0x08, status at 0x0C, and interrupt status/clear at 0x14.
- R3: Control A [3:0] holds the frame length minus one, so a frame has N = field+1 bits. Field values 0 to 2 act as N = 4. A received word holds its N bits in [N-1:0], with the upper bits at zero.
- R4: Control A bit 7 (CPOL) is the idle level of `sclk`. Each frame has 2N `sclk` transitions and sends `mosi` MSB first. `mosi` is stable where the receiver samples: on leading edges when control A bit 6 (CPHA) is 0, and on trailing edges when CPHA is 1.
- R5: With P = prescale[7:1] (0 is treated as 1) and S = control A [15:8], each `sclk` half period lasts P*(S+1) clock cycles. `frame_n` stays low for exactly 2N*P*(S+1) cycles.
- R6: Control B bit 3 selects loopback. In loopback the receiver takes `mosi` and ignores `miso`. Otherwise it takes `miso`.
- R7: Each frame takes one word from the transmit queue and delivers one word to the receive queue. Each queue holds 8 words. Reading the data address while the receive queue is empty returns 0.
- R8: The status bits are: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. Busy means a frame is in progress or the transmit queue is not empty.
- R9: A frame that completes while the receive queue is full is discarded, and an overrun flag is set. The flag stays set until any write to 0x14.
- R10: Interrupt status bit 0 is (receive queue holds at least 4 words) AND control B bit 0. Bit 1 is (port enabled AND transmit queue holds at most 4 words) AND control B bit 1. Bit 2 is the overrun flag AND control B bit 2. `irq` is the OR of these three bits.
- R11: While control B bit 4 (port enable) is 0, shifting stops, both queues are empty, `frame_n` is 1 and data writes are dropped.
- R12: Writes honour the byte enables: `bus_be[0]` covers bits [7:0] and `bus_be[1]` covers bits [15:8]. A data write clears the byte lane that is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data on the data address) |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| frame_n | output | 1 | Active-low frame enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are the overrun and the mid-frame shutdown. An overrun needs eight completed frames left unread, followed by a ninth. The bench fills the receive queue through loopback at the fastest bit rate and then sends one more word. It then drains the queue to show that the first eight words survived and the ninth did not. A shutdown while a frame is still running needs a frame long enough to interrupt, so the bench sets the slowest divider, queues nine words, and clears the enable while the first frame is still shifting. In a separate test the `miso` pin is always driven with the inverse of `mosi`. This makes the loopback and external paths give different answers.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  localparam int DW = 16;

  localparam logic [4:0] OFS_CTLA = 5'h00;
  localparam logic [4:0] OFS_CTLB = 5'h04;
  localparam logic [4:0] OFS_DATA = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_PSC  = 5'h10;
  localparam logic [4:0] OFS_INT  = 5'h14;

  typedef enum logic {SH_IDLE, SH_XFER} sh_state_t;

  // Bits per frame from the length field; the smallest legal frame is 4 bits.
  function automatic logic [4:0] frame_bits(input logic [3:0] fld);
    return (fld < 4'd3) ? 5'd4 : ({1'b0, fld} + 5'd1);
  endfunction

  // Half period of sclk in system clocks: prescale/2 times (rate+1).
  function automatic logic [15:0] half_period(input logic [6:0] psc_half,
                                              input logic [7:0] rate);
    logic [6:0] p;
    p = (psc_half == 7'd0) ? 7'd1 : psc_half;
    return 16'(p) * (16'(rate) + 16'd1);
  endfunction

endpackage

// File: rtl/ssm_fifo.sv
module ssm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter
  import ssm_pkg::*;
#(
  parameter int W   = DW,
  parameter int HPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           cpol,
  input  logic           cpha,
  input  logic [4:0]     nbits,
  input  logic [HPW-1:0] half_per,
  input  logic           tx_avail,
  input  logic [W-1:0]   tx_data,
  input  logic           rx_in,
  output logic           tx_pop,
  output logic           sclk,
  output logic           mosi,
  output logic           active,
  output logic           done,
  output logic [W-1:0]   rx_word
);
  sh_state_t      state;
  logic [HPW-1:0] tcnt;
  logic [5:0]     edge_i;
  logic [W-1:0]   tsr, rsr, rx_shift;
  logic           sclk_r;
  logic           edge_tick, last_edge, leading, sample_now, launch_now;
  logic [5:0]     last_idx;

  assign last_idx   = {nbits, 1'b0} - 6'd1;
  assign edge_tick  = (state == SH_XFER) && (tcnt == '0);
  assign last_edge  = (edge_i == last_idx);
  assign leading    = !edge_i[0];
  assign sample_now = edge_tick && (leading ^ cpha);
  assign launch_now = edge_tick && !(leading ^ cpha) && (edge_i != 6'd0) && !last_edge;
  assign rx_shift   = {rsr[W-2:0], rx_in};

  assign tx_pop  = enable && (state == SH_IDLE) && tx_avail;
  assign done    = edge_tick && last_edge;
  assign rx_word = sample_now ? rx_shift : rsr;
  assign active  = (state == SH_XFER);
  assign sclk    = sclk_r;
  assign mosi    = tsr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SH_IDLE;
      tcnt   <= '0;
      edge_i <= '0;
      tsr    <= '0;
      rsr    <= '0;
      sclk_r <= 1'b0;
    end else if (!enable) begin
      state  <= SH_IDLE;
      tcnt   <= '0;
      edge_i <= '0;
      sclk_r <= cpol;
    end else begin
      case (state)
        SH_IDLE: begin
          sclk_r <= cpol;
          if (tx_avail) begin
            state  <= SH_XFER;
            tsr    <= tx_data << (5'(W) - nbits);
            rsr    <= '0;
            edge_i <= '0;
            tcnt   <= half_per - 1'b1;
          end
        end
        default: begin
          if (tcnt != '0) begin
            tcnt <= tcnt - 1'b1;
          end else begin
            tcnt   <= half_per - 1'b1;
            sclk_r <= ~sclk_r;
            edge_i <= edge_i + 6'd1;
            if (sample_now) rsr <= rx_shift;
            if (launch_now) tsr <= {tsr[W-2:0], 1'b0};
            if (last_edge)  state <= SH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int IRQ_LEVEL  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        frame_n,
  output logic        irq
);
  localparam int CW = $clog2(FIFO_DEPTH+1);
  localparam logic [CW-1:0] LVL = CW'(IRQ_LEVEL);

  logic [15:0]   ctl0;
  logic [6:0]    ctl1;
  logic [6:0]    psc_half;
  logic          ror_flag;

  // Named events for the checker
  logic          port_en, loopback, frame_done, ovr_event, shift_active;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic [DW-1:0] tx_word, tx_head, rx_head, rx_word;
  logic [4:0]    nbits;
  logic [15:0]   hper;
  logic          rx_req, tx_req, rx_in;
  logic [2:0]    int_stat;
  logic [4:0]    status;
  logic          hit_ctla, hit_ctlb, hit_data, hit_stat, hit_psc, hit_int;

  assign hit_ctla = (bus_addr == OFS_CTLA);
  assign hit_ctlb = (bus_addr == OFS_CTLB);
  assign hit_data = (bus_addr == OFS_DATA);
  assign hit_stat = (bus_addr == OFS_STAT);
  assign hit_psc  = (bus_addr == OFS_PSC);
  assign hit_int  = (bus_addr == OFS_INT);

  assign port_en  = ctl1[4];
  assign loopback = ctl1[3];
  assign nbits    = frame_bits(ctl0[3:0]);
  assign hper     = half_period(psc_half, ctl0[15:8]);

  assign tx_word  = {bus_be[1] ? bus_wdata[15:8] : 8'h00,
                     bus_be[0] ? bus_wdata[7:0]  : 8'h00};
  assign tx_push  = bus_wr && hit_data && port_en && (bus_be != 2'b00);
  assign rx_pop   = bus_rd && hit_data && !rx_empty;
  assign rx_push  = frame_done && !rx_full;
  assign ovr_event = frame_done && rx_full;
  assign rx_in    = loopback ? mosi : miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0     <= '0;
      ctl1     <= '0;
      psc_half <= '0;
      ror_flag <= 1'b0;
    end else begin
      if (bus_wr && hit_ctla && bus_be[0]) ctl0[7:0]  <= bus_wdata[7:0];
      if (bus_wr && hit_ctla && bus_be[1]) ctl0[15:8] <= bus_wdata[15:8];
      if (bus_wr && hit_ctlb && bus_be[0]) ctl1       <= bus_wdata[6:0];
      if (bus_wr && hit_psc  && bus_be[0]) psc_half   <= bus_wdata[7:1];
      if (ovr_event)                 ror_flag <= 1'b1;
      else if (bus_wr && hit_int)    ror_flag <= 1'b0;
    end
  end

  ssm_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!port_en),
    .push(tx_push), .wdata(tx_word), .pop(tx_pop), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  ssm_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!port_en),
    .push(rx_push), .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  ssm_shifter #(.W(DW), .HPW(16)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(port_en),
    .cpol(ctl0[7]), .cpha(ctl0[6]), .nbits(nbits), .half_per(hper),
    .tx_avail(!tx_empty), .tx_data(tx_head), .rx_in(rx_in),
    .tx_pop(tx_pop), .sclk(sclk), .mosi(mosi), .active(shift_active),
    .done(frame_done), .rx_word(rx_word)
  );

  assign frame_n  = !shift_active;
  assign rx_req   = (rx_cnt >= LVL);
  assign tx_req   = port_en && (tx_cnt <= LVL);
  assign int_stat = {ror_flag & ctl1[2], tx_req & ctl1[1], rx_req & ctl1[0]};
  assign irq      = |int_stat;
  assign status   = {shift_active || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};

  always_comb begin
    bus_rdata = 16'h0000;
    if (hit_ctla)      bus_rdata = ctl0;
    else if (hit_ctlb) bus_rdata = {9'd0, ctl1};
    else if (hit_data) bus_rdata = rx_empty ? 16'h0000 : rx_head;
    else if (hit_stat) bus_rdata = {11'd0, status};
    else if (hit_psc)  bus_rdata = {8'd0, psc_half, 1'b0};
    else if (hit_int)  bus_rdata = {13'd0, int_stat};
  end
endmodule

// File: rtl/ssm_checks.sv
module ssm_checks #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sclk,
  input logic                       frame_n,
  input logic                       cpol,
  input logic                       port_en,
  input logic                       frame_done,
  input logic                       rx_full,
  input logic                       ror_flag,
  input logic                       irq,
  input logic [6:0]                 ctl1,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt
);
  localparam int CW = $clog2(DEPTH+1);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n && $past(frame_n) && $stable(cpol) |-> (sclk == cpol));

  // R9
  overrun_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && rx_full |=> ror_flag);

  // R11
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (tx_cnt == '0) && (rx_cnt == '0) && frame_n);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl1[2:0] != 3'b000));

  // R7
  frame_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> ($past(tx_cnt) != '0));
endmodule

bind sync_serial_master ssm_checks #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .cpol(ctl0[7]),
  .port_en(port_en), .frame_done(frame_done), .rx_full(rx_full),
  .ror_flag(ror_flag), .irq(irq), .ctl1(ctl1), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sync_serial_master_tb.sv
module sync_serial_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_be = 2'b11;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, miso, frame_n, irq;

  always #5 clk = ~clk;
  assign miso = ~mosi;

  sync_serial_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .frame_n(frame_n), .irq(irq)
  );

  localparam logic [4:0] A_CA = 5'h00, A_CB = 5'h04, A_DT = 5'h08,
                         A_ST = 5'h0C, A_PS = 5'h10, A_IN = 5'h14;

  int checks = 0, fails = 0;

  // Bench-side slave model and frame measurement
  logic        sclk_q, fn_q = 1'b1;
  logic        cpol_c = 1'b0, cpha_c = 1'b0;
  int          tog = 0, lowc = 0;
  logic [15:0] cap = '0;

  always @(posedge clk) begin
    if (!frame_n) lowc++;
    if ((sclk !== sclk_q) && !fn_q) begin
      tog++;
      if ((sclk != cpol_c) ^ cpha_c) cap = {cap[14:0], mosi};
    end
    sclk_q <= sclk;
    fn_q   <= frame_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(A_ST, s);
      if (!s[4]) break;
    end
  endtask

  task automatic run_frame(input logic [3:0] f, input logic cp, input logic ch,
                           input logic lb, input logic [7:0] psc,
                           input logic [7:0] scr, input logic [15:0] d);
    logic [15:0] v, mask;
    int n, hp;
    n    = (f < 3) ? 4 : f + 1;
    mask = 16'((32'h1 << n) - 1);
    hp   = ((psc >> 1) == 0 ? 1 : (psc >> 1)) * (scr + 1);
    cpol_c = cp; cpha_c = ch;
    wr(A_CB, 16'h0000, 2'b11);
    wr(A_CA, {scr, cp, ch, 2'b00, f}, 2'b11);
    wr(A_PS, {8'h00, psc}, 2'b11);
    wr(A_CB, lb ? 16'h0018 : 16'h0010, 2'b11);
    tog = 0; lowc = 0; cap = '0;
    wr(A_DT, d, 2'b11);
    wait_idle();
    rd(A_DT, v);
    if (lb) chk($sformatf("R3 R6 loopback word n=%0d mode=%0d", n, {cp, ch}), v, d & mask);
    else    chk($sformatf("R3 R6 external word n=%0d mode=%0d", n, {cp, ch}), v, ~d & mask);
    chk($sformatf("R4 mosi bits n=%0d mode=%0d", n, {cp, ch}), cap & mask, d & mask);
    chk($sformatf("R4 sclk edges n=%0d", n), tog, 2 * n);
    chk($sformatf("R5 frame length n=%0d hp=%0d", n, hp), lowc, 2 * n * hp);
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 frame_n", frame_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 irq", irq, 0);
    rd(A_ST, v); chk("R1 status", v, 16'h0003);
    rd(A_CA, v); chk("R1 ctrl A", v, 0);
    rd(A_CB, v); chk("R1 ctrl B", v, 0);
    rd(A_PS, v); chk("R1 prescale", v, 0);

    // R2 / R12 register storage and byte lanes
    wr(A_CA, 16'hA5C7, 2'b11); rd(A_CA, v); chk("R2 ctrl A full", v, 16'hA5C7);
    wr(A_CA, 16'h1234, 2'b01); rd(A_CA, v); chk("R12 ctrl A low lane", v, 16'hA534);
    wr(A_CA, 16'h56FF, 2'b10); rd(A_CA, v); chk("R12 ctrl A high lane", v, 16'h5634);
    wr(A_PS, 16'h000F, 2'b11); rd(A_PS, v); chk("R2 prescale bit0", v, 16'h000E);
    wr(A_CB, 16'hFF6F, 2'b11); rd(A_CB, v); chk("R2 ctrl B width", v, 16'h006F);
    wr(A_CB, 16'h0000, 2'b11);

    // Sweep: all modes, all frame lengths, alternate loopback and external
    for (int m = 0; m < 4; m++) begin
      for (int f = 3; f < 16; f++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run_frame(4'(f), m[1], m[0], (f % 2) == 0, (f % 2) ? 8'd4 : 8'd2,
                  8'(f % 3), lfsr);
      end
    end
    // R3 short length fields act as 4 bits
    for (int f = 0; f < 3; f++) run_frame(4'(f), 1'b0, 1'b1, 1'b1, 8'd2, 8'd1, 16'hBEEF);

    // R7..R10 queue depth, watermarks, overrun
    wr(A_CB, 16'h0000, 2'b11);
    wr(A_CA, 16'h0007, 2'b11);
    wr(A_PS, 16'h0002, 2'b11);
    cpol_c = 0; cpha_c = 0;
    wr(A_CB, 16'h001F, 2'b11);
    rd(A_IN, v); chk("R10 tx pending when empty", v, 16'h0002);
    chk("R10 irq asserted", irq, 1);
    for (int i = 0; i < 3; i++) begin wr(A_DT, 16'(8'h10 + i), 2'b11); wait_idle(); end
    rd(A_IN, v); chk("R10 rx below watermark", v, 16'h0002);
    rd(A_ST, v); chk("R8 status rx not empty", v, 16'h0007);
    wr(A_DT, 16'h0013, 2'b11); wait_idle();
    rd(A_IN, v); chk("R10 rx at watermark", v, 16'h0003);
    for (int i = 4; i < 8; i++) begin wr(A_DT, 16'(8'h10 + i), 2'b11); wait_idle(); end
    rd(A_ST, v); chk("R8 status rx full", v, 16'h000F);
    wr(A_DT, 16'h0018, 2'b11); wait_idle();
    rd(A_IN, v); chk("R9 overrun reported", v, 16'h0007);
    for (int i = 0; i < 8; i++) begin
      rd(A_DT, v); chk($sformatf("R7 R9 kept word %0d", i), v, 16'(8'h10 + i));
    end
    rd(A_DT, v); chk("R7 empty read gives 0", v, 16'h0000);
    rd(A_ST, v); chk("R8 status drained", v, 16'h0003);
    rd(A_IN, v); chk("R9 overrun sticky", v, 16'h0006);
    wr(A_IN, 16'h0000, 2'b11);
    rd(A_IN, v); chk("R9 overrun cleared", v, 16'h0002);
    wr(A_CB, 16'h0007, 2'b11);
    rd(A_IN, v); chk("R10 tx pending needs enable", v, 16'h0000);
    chk("R10 irq low when disabled", irq, 0);

    // R11 shutdown mid-frame with a full transmit queue
    wr(A_CA, 16'hFF07, 2'b11);
    wr(A_PS, 16'h00FE, 2'b11);
    wr(A_CB, 16'h001A, 2'b11);
    for (int i = 0; i < 9; i++) wr(A_DT, 16'(i), 2'b11);
    rd(A_ST, v); chk("R8 status tx full busy", v, 16'h0010);
    rd(A_IN, v); chk("R10 tx not pending when full", v, 16'h0000);
    chk("R11 frame running", frame_n, 0);
    wr(A_CB, 16'h0008, 2'b11);
    rd(A_ST, v); chk("R11 queues flushed", v, 16'h0003);
    chk("R11 frame stopped", frame_n, 1);
    chk("R11 sclk idle", sclk, 0);
    wr(A_DT, 16'h0055, 2'b11);
    rd(A_ST, v); chk("R11 write dropped while off", v, 16'h0003);
    wr(A_PS, 16'h0002, 2'b11);
    wr(A_CA, 16'h000F, 2'b11);
    wr(A_CB, 16'h0018, 2'b11);
    repeat (60) @(negedge clk);
    rd(A_ST, v); chk("R11 nothing sent after re-enable", v, 16'h0003);

    // R12 data byte lanes, 16-bit loopback frame
    wr(A_DT, 16'hABCD, 2'b01); wait_idle();
    rd(A_DT, v); chk("R12 data low lane only", v, 16'h00CD);
    wr(A_DT, 16'hABCD, 2'b10); wait_idle();
    rd(A_DT, v); chk("R12 data high lane only", v, 16'hAB00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule